// File: doc/BRIEF.md
# Shared Address/Data Bus Port Pair

This block owns sixteen pads arranged as two 8-bit ports. When the external memory bus is idle, the pads act as general-purpose I/O. A drive-select register picks push-pull or open-drain output for each whole port. Two data registers hold the values the user wants on the pads. Two pin-status outputs return the pad levels sampled at the clock.

When the bus-cycle interface raises its active flag, the block gives the pads to the bus and ignores the GPIO settings. In the address phase of multiplexed mode, the pads carry the low 16 address bits. In demultiplexed mode the pads are released during the address phase. In the data phase the pads drive write data, or they float so that read data can be captured into a separate read-data output.

When the cycle ends, the stored GPIO drive returns without any register rewrite. The timing generator for external memory is outside this block; the block only decides who owns each pad. Port A is pads 7:0 and port B is pads 15:8.

Top module: `shared_bus_port`

## Requirements
- R1: After reset the drive-select register is 0 and both data registers are all ones, so with the bus idle every pad enable (pad_oe_o) is 0.
- R2: A register write uses wr_sel_i=0 for drive-select, 1 for port A data and 2 for port B data. With the bus idle, drive-select bit 7 = 1 makes port A push-pull: pad_oe_o[7:0]=FF and pad_out_o[7:0] equals the port A data.
- R3: With the bus idle, drive-select bit 6 = 1 makes port B push-pull: pad_oe_o[15:8]=FF and pad_out_o[15:8] equals the port B data.
- R4: With the bus idle and a port in open-drain (its drive-select bit 0), each pad with data bit 0 is enabled and driven low. Each pad with data bit 1 has its enable off, so it floats and can serve as an input. pad_out_o is 0 for that port.
- R5: While the bus is idle, pin_a_o and pin_b_o show pad_in_i as sampled at the previous rising clock edge.
- R6: During an address phase (bus_act_i=1, bus_addr_ph_i=1) in multiplexed mode (bus_demux_i=0), all 16 pads are enabled and carry bus_addr_i.
- R7: During an address phase in demultiplexed mode (bus_demux_i=1), all pads are released (pad_oe_o=0, pad_out_o=0).
- R8: During a write data phase (bus_act_i=1, bus_addr_ph_i=0, bus_wr_i=1), all pads are enabled and carry bus_wdata_i in either mode.
- R9: During a read data phase (bus_act_i=1, bus_addr_ph_i=0, bus_wr_i=0), all pads are released. At the next edge bus_rdata_o captures pad_in_i and bus_rvalid_o is 1 for one cycle per read-phase cycle.
- R10: While bus_act_i=1, the pin-status outputs hold their last value. Bus read data never enters them.
- R11: Register writes made during a bus cycle are stored. They appear on the pads, together with the rest of the GPIO drive, as soon as bus_act_i falls. wr_sel_i=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 drive-select, 1 port A data, 2 port B data, 3 none |
| wr_data_i | input | 8 | Register write data |
| bus_act_i | input | 1 | External bus cycle in progress |
| bus_addr_ph_i | input | 1 | 1 = address phase, 0 = data phase |
| bus_wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_demux_i | input | 1 | 1 = demultiplexed bus mode |
| bus_addr_i | input | 16 | Bus address, low 16 bits |
| bus_wdata_i | input | 16 | Bus write data |
| bus_rdata_o | output | 16 | Captured bus read data |
| bus_rvalid_o | output | 1 | bus_rdata_o updated at the last edge |
| pad_in_i | input | 16 | Pad input levels |
| pad_out_o | output | 16 | Pad output values |
| pad_oe_o | output | 16 | Pad output enables |
| pin_a_o | output | 8 | Port A pin status |
| pin_b_o | output | 8 | Port B pin status |

## Verification
The bench writes a data register during a bus cycle and checks two things. The pads must keep the bus value while the cycle runs, and the new value must appear at once when the cycle ends. A design that writes through to the pads, or that drops the write, fails here.

In the read phase the bench changes pad_in_i. A design that lets bus traffic into the pin status, or that forgets to float the pads, is caught by the pin-status and enable comparisons. The bench also sets the two drive-select bits one at a time. A design that swaps the bits, or mixes up push-pull and open-drain, shows wrong enables on the wrong port.

// File: rtl/shared_bus_pkg.sv
package shared_bus_pkg;
  typedef enum logic [1:0] {
    SEL_DRV    = 2'd0,
    SEL_DATA_A = 2'd1,
    SEL_DATA_B = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned CMP_BIT_A = 7;
  localparam int unsigned CMP_BIT_B = 6;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import shared_bus_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] drv_o,
  output logic [W-1:0] data_a_o,
  output logic [W-1:0] data_b_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_o    <= '0;
      data_a_o <= '1;
      data_b_o <= '1;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_DRV:    drv_o    <= wr_data_i;
        SEL_DATA_A: data_a_o <= wr_data_i;
        SEL_DATA_B: data_b_o <= wr_data_i;
        default: ;
      endcase
    end
  end

  // R11: contents only move on a write strobe
  a_r11_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(drv_o) && $stable(data_a_o) && $stable(data_b_o)));
endmodule

// File: rtl/pad_owner_mux.sv
module pad_owner_mux #(
  parameter int unsigned W     = 8,
  parameter int unsigned NPORT = 2,
  localparam int unsigned BW   = W * NPORT
) (
  input  logic [NPORT-1:0] cmp_i,
  input  logic [BW-1:0]    gpio_data_i,
  input  logic             bus_act_i,
  input  logic             addr_ph_i,
  input  logic             bus_wr_i,
  input  logic             demux_i,
  input  logic [BW-1:0]    bus_addr_i,
  input  logic [BW-1:0]    bus_wdata_i,
  output logic [BW-1:0]    pad_out_o,
  output logic [BW-1:0]    pad_oe_o
);
  logic [BW-1:0] gpio_out, gpio_oe;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [W-1:0] d;
    assign d = gpio_data_i[p*W +: W];
    // open-drain: 0 pulls low, 1 floats
    assign gpio_out[p*W +: W] = cmp_i[p] ? d : '0;
    assign gpio_oe[p*W +: W]  = cmp_i[p] ? '1 : ~d;
  end

  always_comb begin
    pad_out_o = gpio_out;
    pad_oe_o  = gpio_oe;
    if (bus_act_i) begin
      pad_out_o = '0;
      pad_oe_o  = '0;
      if (addr_ph_i) begin
        if (!demux_i) begin
          pad_out_o = bus_addr_i;
          pad_oe_o  = '1;
        end
      end else if (bus_wr_i) begin
        pad_out_o = bus_wdata_i;
        pad_oe_o  = '1;
      end
    end
  end
endmodule

// File: rtl/bus_capture.sv
module bus_capture #(
  parameter int unsigned BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_act_i,
  input  logic          addr_ph_i,
  input  logic          bus_wr_i,
  input  logic [BW-1:0] pad_in_i,
  output logic [BW-1:0] pin_o,
  output logic [BW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic rd_ph;
  assign rd_ph = bus_act_i && !addr_ph_i && !bus_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      if (!bus_act_i) pin_o <= pad_in_i;
      if (rd_ph) rdata_o <= pad_in_i;
      rvalid_o <= rd_ph;
    end
  end

  a_r10_pin_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act_i |=> $stable(pin_o));
  a_r9_rvalid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_act_i && !addr_ph_i && !bus_wr_i) |=> rvalid_o);
  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_act_i && !addr_ph_i && !bus_wr_i) |=> $stable(rdata_o));
endmodule

// File: rtl/shared_bus_port.sv
module shared_bus_port
  import shared_bus_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned BUS_W = 2 * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [PORT_W-1:0] wr_data_i,
  input  logic              bus_act_i,
  input  logic              bus_addr_ph_i,
  input  logic              bus_wr_i,
  input  logic              bus_demux_i,
  input  logic [BUS_W-1:0]  bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [BUS_W-1:0]  pad_in_i,
  output logic [BUS_W-1:0]  pad_out_o,
  output logic [BUS_W-1:0]  pad_oe_o,
  output logic [PORT_W-1:0] pin_a_o,
  output logic [PORT_W-1:0] pin_b_o
);
  logic [PORT_W-1:0] drv, data_a, data_b;
  logic [BUS_W-1:0]  pin_all;

  gpio_regs #(.W(PORT_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .drv_o     (drv),
    .data_a_o  (data_a),
    .data_b_o  (data_b)
  );

  pad_owner_mux #(.W(PORT_W), .NPORT(2)) i_mux (
    .cmp_i       ({drv[CMP_BIT_B], drv[CMP_BIT_A]}),
    .gpio_data_i ({data_b, data_a}),
    .bus_act_i   (bus_act_i),
    .addr_ph_i   (bus_addr_ph_i),
    .bus_wr_i    (bus_wr_i),
    .demux_i     (bus_demux_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o)
  );

  bus_capture #(.BW(BUS_W)) i_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_act_i (bus_act_i),
    .addr_ph_i (bus_addr_ph_i),
    .bus_wr_i  (bus_wr_i),
    .pad_in_i  (pad_in_i),
    .pin_o     (pin_all),
    .rdata_o   (bus_rdata_o),
    .rvalid_o  (bus_rvalid_o)
  );

  assign pin_a_o = pin_all[PORT_W-1:0];
  assign pin_b_o = pin_all[BUS_W-1:PORT_W];

  a_r6_mux_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_act_i && bus_addr_ph_i && !bus_demux_i) |-> (&pad_oe_o && pad_out_o == bus_addr_i));
  a_r7_demux_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_act_i && bus_addr_ph_i && bus_demux_i) |-> (pad_oe_o == '0));
  a_r8_write_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_act_i && !bus_addr_ph_i && bus_wr_i) |-> (&pad_oe_o && pad_out_o == bus_wdata_i));
  a_r9_read_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_act_i && !bus_addr_ph_i && !bus_wr_i) |-> (pad_oe_o == '0));
  a_r4_od_low_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_act_i && !drv[CMP_BIT_A]) |-> (pad_out_o[PORT_W-1:0] == '0));
endmodule

// File: tb/test_shared_bus_port.sv
module test_shared_bus_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'h00;
  logic        bus_act = 1'b0, bus_addr_ph = 1'b0, bus_wr = 1'b0, bus_demux = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, pad_in = '0;
  logic [15:0] bus_rdata, pad_out, pad_oe;
  logic        bus_rvalid;
  logic [7:0]  pin_a, pin_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_bus_port i_shared_bus_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .bus_act_i(bus_act), .bus_addr_ph_i(bus_addr_ph), .bus_wr_i(bus_wr), .bus_demux_i(bus_demux),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pin_a_o(pin_a), .pin_b_o(pin_b)
  );

  typedef struct {
    string       req;
    logic [15:0] oe, out, pin, rd;
    logic        rv;
  } exp_t;

  exp_t q[$];
  event ev_sample;
  int total = 0, bad = 0;

  // bench model
  logic [7:0]  m_drv = 8'h00, m_da = 8'hFF, m_db = 8'hFF;
  logic [15:0] m_pin = '0, m_rd = '0;
  logic        m_rv = 1'b0;

  task automatic step(input string req, input logic we, input logic [1:0] sel, input logic [7:0] wd,
                      input logic act, input logic ph, input logic bw, input logic dm,
                      input logic [15:0] ad, input logic [15:0] wdat, input logic [15:0] pin_in);
    exp_t e;
    logic [7:0] d [2];
    logic       c [2];
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = wd;
    bus_act = act; bus_addr_ph = ph; bus_wr = bw; bus_demux = dm;
    bus_addr = ad; bus_wdata = wdat; pad_in = pin_in;
    e.req = req;
    if (act) begin
      if (ph && !dm)      begin e.oe = 16'hFFFF; e.out = ad;   end
      else if (!ph && bw) begin e.oe = 16'hFFFF; e.out = wdat; end
      else                begin e.oe = 16'h0000; e.out = '0;   end
    end else begin
      d[0] = m_da; d[1] = m_db; c[0] = m_drv[7]; c[1] = m_drv[6];
      for (int p = 0; p < 2; p++) begin
        e.oe[p*8 +: 8]  = c[p] ? 8'hFF : ~d[p];
        e.out[p*8 +: 8] = c[p] ? d[p] : 8'h00;
      end
    end
    e.pin = m_pin; e.rd = m_rd; e.rv = m_rv;
    q.push_back(e);
    ->ev_sample;
    // state after the coming edge
    if (we) begin
      case (sel)
        2'd0: m_drv = wd;
        2'd1: m_da = wd;
        2'd2: m_db = wd;
        default: ;
      endcase
    end
    if (!act) m_pin = pin_in;
    m_rv = act && !ph && !bw;
    if (m_rv) m_rd = pin_in;
  endtask

  task automatic idle(input string req, input logic [15:0] pin_in);
    step(req, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, pin_in);
  endtask

  task automatic wreg(input string req, input logic [1:0] sel, input logic [7:0] wd);
    step(req, 1'b1, sel, wd, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0);
  endtask

  // monitor
  initial begin
    forever begin
      @(ev_sample);
      #1;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (pad_oe !== e.oe || pad_out !== e.out || {pin_b, pin_a} !== e.pin ||
            bus_rdata !== e.rd || bus_rvalid !== e.rv) begin
          bad++;
          $display("FAIL %s: oe=%h out=%h pin=%h rd=%h rv=%b expected oe=%h out=%h pin=%h rd=%h rv=%b",
                   e.req, pad_oe, pad_out, {pin_b, pin_a}, bus_rdata, bus_rvalid,
                   e.oe, e.out, e.pin, e.rd, e.rv);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1 reset state", 16'h0000);
    // R4 open-drain on port A
    wreg("R4 setup", 2'd1, 8'h5A);
    idle("R4 open-drain A", 16'h0000);
    // R2 port A push-pull
    wreg("R2 setup", 2'd0, 8'h80);
    idle("R2 port A complementary", 16'h0000);
    // R3 port B push-pull, port A back to open-drain
    wreg("R3 setup data", 2'd2, 8'h3C);
    wreg("R3 setup drv", 2'd0, 8'h40);
    idle("R3 port B complementary", 16'h0000);
    // R5 pin status
    idle("R5 drive pads", 16'h1234);
    idle("R5 pin status", 16'hA5C3);
    idle("R5 pin status next", 16'hA5C3);
    // R6 mux address phase, with a port A write held off (R11)
    step("R6 mux addr + R11 write", 1'b1, 2'd1, 8'h0F, 1'b1, 1'b1, 1'b0, 1'b0, 16'hBEEF, 16'h0, 16'h7777);
    step("R8 write data phase", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 16'hBEEF, 16'h1357, 16'h8888);
    idle("R11 restore after write cycle", 16'h00FF);
    // R7/R9/R10 demux read cycle
    step("R7 demux addr", 1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 16'h4321, 16'h0, 16'h9999);
    step("R9 read phase", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h4321, 16'h0, 16'hCAFE);
    step("R10 pin hold in read", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h4321, 16'h0, 16'hF00D);
    idle("R9 capture after read", 16'h0101);
    idle("R9 rvalid drop", 16'h0101);
    // R8 write phase in demux mode
    step("R8 demux write", 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0, 16'h2468, 16'h0101);
    // R11 unused select ignored
    wreg("R11 sel3 write", 2'd3, 8'h00);
    idle("R11 sel3 no effect", 16'h0101);
    // R2/R3 both push-pull
    wreg("R2 both drv", 2'd0, 8'hC0);
    idle("R2 R3 both complementary", 16'h0202);
    // R4 float all for input use
    wreg("R4 data A ones", 2'd1, 8'hFF);
    wreg("R4 drv clear", 2'd0, 8'h00);
    idle("R4 A floats, B od", 16'h0202);
    @(negedge clk);
    #2;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: pending=%0d expected=0", q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule